// File: doc/BRIEF.md
# Pixel Test Counter Generator

This block produces a known 16-bit ramp that stands in for converted pixel data, so the pixel-processing path can be exercised digitally without a live converter. On every data pixel the ramp moves forward by a step chosen from 1, 4 or 16. It falls back to zero at a chosen boundary: either the start of each scan or the start of each line.

A two-bit mode input picks the source. In the plain converter mode the ramp is held at zero and the select output stays low, so the downstream multiplexer passes converter data. In either counter mode the select output goes high and each counter pixel is presented on the value output, with a one-cycle valid strobe. The value is held between pixels.

Top module: `ptc_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `tc_value` is 0 and `tc_sel` and `tc_valid` are 0.
- R2: `tc_sel` is 1 one cycle after `src_mode` is 2'b01 (restart per scan) or 2'b10 (restart per line), and 0 one cycle after `src_mode` is 2'b00 (converter data) or 2'b11 (reserved, also converter data).
- R3: In a counter mode, each pixel strobe with no restart in the same cycle gives a value one step above the previous pixel's value; `step_code` 2'b00 steps by 1, 2'b01 by 4, 2'b10 by 16.
- R4: The count wraps modulo 65536: with step 16, the pixel after the value 65520 reads 0.
- R5: With `src_mode` 2'b01, a `scan_start` pulse makes the next pixel read 0, and a `line_start` pulse has no effect on the ramp.
- R6: With `src_mode` 2'b10, a pulse on either `line_start` or `scan_start` makes the next pixel read 0.
- R7: A restart pulse in the same cycle as a pixel strobe gives 0 for that pixel, and the pixel after it reads one step.
- R8: `step_code` 2'b11 steps by 1.
- R9: In converter mode (2'b00 or 2'b11) pixels give no valid strobe, `tc_value` is 0 and the count is cleared, so the first counter pixel after leaving it reads 0.
- R10: `tc_valid` pulses and `tc_value` updates one cycle after each pixel strobe in a counter mode; between pixels `tc_value` holds and `tc_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_strobe | input | 1 | One data pixel this cycle |
| scan_start | input | 1 | Start-of-scan pulse |
| line_start | input | 1 | Start-of-line pulse |
| src_mode | input | 2 | 00 converter, 01 ramp restart per scan, 10 ramp restart per line, 11 converter |
| step_code | input | 2 | 00 step 1, 01 step 4, 10 step 16, 11 step 1 |
| tc_value | output | 16 | Ramp value of the last counter pixel |
| tc_valid | output | 1 | New ramp value this cycle |
| tc_sel | output | 1 | Steer downstream multiplexer to the ramp |

## Verification
The assertions take for granted that `src_mode`, `step_code` and the strobes are driven to known levels from the first clock edge and change only between edges, since the select and step checks compare against the previous cycle's controls. They assume nothing about the spacing of pulses, so restart and pixel strobes may coincide or arrive back to back. The stimulus changes every input on the falling clock edge, starts each scenario with a lone restart, and includes coinciding restart and pixel strobes on purpose to reach the R7 path.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

    typedef enum logic [1:0] {
        SRC_ADC  = 2'b00,
        SRC_SCAN = 2'b01,
        SRC_LINE = 2'b10,
        SRC_RSVD = 2'b11
    } src_mode_e;

    // Counter modes are the only ones that drive the ramp.
    function automatic logic is_ramp_mode(src_mode_e m);
        return (m == SRC_SCAN) || (m == SRC_LINE);
    endfunction

endpackage

// File: rtl/ptc_step_dec.sv
module ptc_step_dec #(
    parameter int CNT_W          = 16,
    parameter int STEP_W         = 2,
    parameter int SHIFT_PER_CODE = 2
) (
    input  logic [STEP_W-1:0] step_code,
    output logic [CNT_W-1:0]  step_amt
);
    localparam int NCODES = 1 << STEP_W;

    logic [CNT_W-1:0] amt_lut [NCODES];

    // Each code scales by 2^(SHIFT_PER_CODE*code); the top code is reserved
    // and falls back to a unit step (R8).
    for (genvar c = 0; c < NCODES; c++) begin : g_code
        if (c == NCODES - 1) begin : g_rsvd
            assign amt_lut[c] = CNT_W'(1);
        end else begin : g_pow
            assign amt_lut[c] = CNT_W'(1) << (c * SHIFT_PER_CODE);
        end
    end

    assign step_amt = amt_lut[step_code];

endmodule

// File: rtl/ptc_restart_sel.sv
module ptc_restart_sel
    import ptc_pkg::*;
(
    input  logic [1:0] src_mode,
    input  logic       scan_start,
    input  logic       line_start,
    output logic       ramp_active,
    output logic       restart
);
    src_mode_e mode_e;

    always_comb begin
        mode_e      = src_mode_e'(src_mode);
        ramp_active = is_ramp_mode(mode_e);
        unique case (mode_e)
            SRC_SCAN: restart = scan_start;
            SRC_LINE: restart = scan_start | line_start;
            default:  restart = 1'b0;
        endcase
    end

    // R5: in per-scan mode a line pulse alone never restarts the ramp.
    always_comb begin
        if (mode_e == SRC_SCAN && !scan_start) begin
            p_line_ignored_r5: assert (!restart)
                else $error("line pulse restarted ramp in per-scan mode");
        end
    end

endmodule

// File: rtl/ptc_count_core.sv
module ptc_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_strobe,
    input  logic             ramp_active,
    input  logic             restart,
    input  logic [CNT_W-1:0] step_amt,
    output logic [CNT_W-1:0] value_q,
    output logic             valid_q
);
    typedef struct packed {
        logic [CNT_W-1:0] count;   // value the next pixel will take
        logic [CNT_W-1:0] value;   // value shown for the last pixel
        logic             valid;
    } core_state_t;

    core_state_t st_d, st_q;
    logic [CNT_W-1:0] pix_val;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        pix_val    = restart ? '0 : st_q.count;
        if (!ramp_active) begin
            st_d.count = '0;
            st_d.value = '0;
        end else if (pix_strobe) begin
            st_d.value = pix_val;
            st_d.count = pix_val + step_amt;   // wraps modulo 2^CNT_W
            st_d.valid = 1'b1;
        end else if (restart) begin
            st_d.count = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value_q = st_q.value;
    assign valid_q = st_q.valid;

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_active && pix_strobe && !restart)
        |=> (st_q.count == CNT_W'($past(st_q.count) + $past(step_amt))));

    p_restart_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_active && pix_strobe && restart) |=> (value_q == '0));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ramp_active |=> (st_q.count == '0 && value_q == '0 && !valid_q));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_active && !pix_strobe) |=> ($stable(value_q) && !valid_q));

endmodule

// File: rtl/ptc_gen.sv
module ptc_gen #(
    parameter int CNT_W          = 16,
    parameter int STEP_W         = 2,
    parameter int SHIFT_PER_CODE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_strobe,
    input  logic              scan_start,
    input  logic              line_start,
    input  logic [1:0]        src_mode,
    input  logic [STEP_W-1:0] step_code,
    output logic [CNT_W-1:0]  tc_value,
    output logic              tc_valid,
    output logic              tc_sel
);
    logic             ramp_active;
    logic             restart;
    logic [CNT_W-1:0] step_amt;
    logic             sel_d, sel_q;

    ptc_step_dec #(
        .CNT_W         (CNT_W),
        .STEP_W        (STEP_W),
        .SHIFT_PER_CODE(SHIFT_PER_CODE)
    ) u_step (
        .step_code(step_code),
        .step_amt (step_amt)
    );

    ptc_restart_sel u_restart (
        .src_mode   (src_mode),
        .scan_start (scan_start),
        .line_start (line_start),
        .ramp_active(ramp_active),
        .restart    (restart)
    );

    ptc_count_core #(
        .CNT_W(CNT_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_strobe (pix_strobe),
        .ramp_active(ramp_active),
        .restart    (restart),
        .step_amt   (step_amt),
        .value_q    (tc_value),
        .valid_q    (tc_valid)
    );

    always_comb begin
        sel_d = ramp_active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign tc_sel = sel_q;

    p_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (tc_sel == ($past(src_mode) == 2'b01 || $past(src_mode) == 2'b10)));

endmodule

// File: tb/ptc_gen_bench.sv
module ptc_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_strobe = 1'b0;
    logic        scan_start = 1'b0;
    logic        line_start = 1'b0;
    logic [1:0]  src_mode = 2'b00;
    logic [1:0]  step_code = 2'b00;
    logic [15:0] tc_value;
    logic        tc_valid;
    logic        tc_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ptc_gen u_ptc_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_strobe(pix_strobe),
        .scan_start(scan_start),
        .line_start(line_start),
        .src_mode  (src_mode),
        .step_code (step_code),
        .tc_value  (tc_value),
        .tc_valid  (tc_valid),
        .tc_sel    (tc_sel)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle of stimulus, driven at a falling edge; returns at the next
    // falling edge, when the registered outputs reflect that cycle.
    task automatic cyc(bit pv, bit ss, bit ls);
        pix_strobe = pv;
        scan_start = ss;
        line_start = ls;
        @(negedge clk);
        pix_strobe = 1'b0;
        scan_start = 1'b0;
        line_start = 1'b0;
    endtask

    task automatic pix_expect(string req, logic [15:0] exp);
        cyc(1'b1, 1'b0, 1'b0);
        chk(req, tc_value, exp);
        chk(req, 16'(tc_valid), 16'd1);
    endtask

    task automatic t_reset();
        chk("R1 value", tc_value, 16'd0);
        chk("R1 valid", 16'(tc_valid), 16'd0);
        chk("R1 sel", 16'(tc_sel), 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 value after release", tc_value, 16'd0);
        chk("R1 sel after release", 16'(tc_sel), 16'd0);
    endtask

    task automatic t_steps();
        src_mode = 2'b01;
        step_code = 2'b00;
        cyc(1'b0, 1'b1, 1'b0);
        chk("R2 sel scan mode", 16'(tc_sel), 16'd1);
        pix_expect("R3 step1 p0", 16'd0);
        pix_expect("R3 step1 p1", 16'd1);
        pix_expect("R3 step1 p2", 16'd2);
        step_code = 2'b01;
        cyc(1'b0, 1'b1, 1'b0);
        pix_expect("R3 step4 p0", 16'd0);
        pix_expect("R3 step4 p1", 16'd4);
        pix_expect("R3 step4 p2", 16'd8);
        step_code = 2'b10;
        cyc(1'b0, 1'b1, 1'b0);
        pix_expect("R3 step16 p0", 16'd0);
        pix_expect("R3 step16 p1", 16'd16);
        pix_expect("R3 step16 p2", 16'd32);
        step_code = 2'b11;
        cyc(1'b0, 1'b1, 1'b0);
        pix_expect("R8 code3 p0", 16'd0);
        pix_expect("R8 code3 p1", 16'd1);
        pix_expect("R8 code3 p2", 16'd2);
    endtask

    task automatic t_hold();
        src_mode = 2'b01;
        step_code = 2'b01;
        cyc(1'b0, 1'b1, 1'b0);
        pix_expect("R10 p0", 16'd0);
        pix_expect("R10 p1", 16'd4);
        for (int i = 0; i < 3; i++) begin
            cyc(1'b0, 1'b0, 1'b0);
            chk("R10 held value", tc_value, 16'd4);
            chk("R10 no valid", 16'(tc_valid), 16'd0);
        end
        pix_expect("R10 p2 after gap", 16'd8);
    endtask

    task automatic t_scan_ignores_line();
        src_mode = 2'b01;
        step_code = 2'b00;
        cyc(1'b0, 1'b1, 1'b0);
        pix_expect("R5 p0", 16'd0);
        pix_expect("R5 p1", 16'd1);
        cyc(1'b0, 1'b0, 1'b1);
        chk("R5 value unchanged by line pulse", tc_value, 16'd1);
        pix_expect("R5 ramp continues past line pulse", 16'd2);
        cyc(1'b1, 1'b0, 1'b1);
        chk("R5 line pulse with pixel ignored", tc_value, 16'd3);
        cyc(1'b0, 1'b1, 1'b0);
        pix_expect("R5 scan pulse restarts", 16'd0);
    endtask

    task automatic t_line_mode();
        src_mode = 2'b10;
        step_code = 2'b01;
        cyc(1'b0, 1'b1, 1'b0);
        chk("R2 sel line mode", 16'(tc_sel), 16'd1);
        pix_expect("R6 p0", 16'd0);
        pix_expect("R6 p1", 16'd4);
        cyc(1'b0, 1'b0, 1'b1);
        pix_expect("R6 line pulse restarts", 16'd0);
        pix_expect("R6 p1 after line", 16'd4);
        pix_expect("R6 p2 after line", 16'd8);
        cyc(1'b0, 1'b1, 1'b0);
        pix_expect("R6 scan pulse restarts", 16'd0);
    endtask

    task automatic t_coincident();
        src_mode = 2'b10;
        step_code = 2'b10;
        cyc(1'b0, 1'b1, 1'b0);
        pix_expect("R7 p0", 16'd0);
        pix_expect("R7 p1", 16'd16);
        cyc(1'b1, 1'b0, 1'b1);
        chk("R7 line+pixel gives zero", tc_value, 16'd0);
        chk("R7 line+pixel valid", 16'(tc_valid), 16'd1);
        pix_expect("R7 next after coincident", 16'd16);
        src_mode = 2'b01;
        cyc(1'b1, 1'b1, 1'b0);
        chk("R7 scan+pixel gives zero", tc_value, 16'd0);
        pix_expect("R7 next after scan coincident", 16'd16);
    endtask

    task automatic t_wrap();
        src_mode = 2'b01;
        step_code = 2'b10;
        cyc(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 4096; i++) begin
            cyc(1'b1, 1'b0, 1'b0);
        end
        chk("R4 top value", tc_value, 16'd65520);
        pix_expect("R4 wraps to zero", 16'd0);
        pix_expect("R4 after wrap", 16'd16);
    endtask

    task automatic t_converter();
        src_mode = 2'b01;
        step_code = 2'b00;
        cyc(1'b0, 1'b1, 1'b0);
        pix_expect("R9 pre p0", 16'd0);
        pix_expect("R9 pre p1", 16'd1);
        src_mode = 2'b00;
        cyc(1'b1, 1'b0, 1'b0);
        chk("R9 adc value zero", tc_value, 16'd0);
        chk("R9 adc no valid", 16'(tc_valid), 16'd0);
        chk("R2 sel adc mode", 16'(tc_sel), 16'd0);
        src_mode = 2'b11;
        cyc(1'b1, 1'b0, 1'b0);
        chk("R9 reserved value zero", tc_value, 16'd0);
        chk("R9 reserved no valid", 16'(tc_valid), 16'd0);
        chk("R2 sel reserved mode", 16'(tc_sel), 16'd0);
        src_mode = 2'b01;
        cyc(1'b0, 1'b0, 1'b0);
        chk("R2 sel back to ramp", 16'(tc_sel), 16'd1);
        pix_expect("R9 ramp restarts at zero", 16'd0);
        pix_expect("R9 ramp then steps", 16'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_steps();
        t_hold();
        t_scan_ignores_line();
        t_line_mode();
        t_coincident();
        t_wrap();
        t_converter();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule